// File: doc/BRIEF.md
# Single-Accumulator Execution Unit

This block executes a stream of one-address instructions against an 8-bit accumulator. Each instruction carries a 3-bit opcode and one 16-bit data memory address. The accumulator supplies one operand and receives every result. The byte at the named address supplies the other operand. A STORE writes the accumulator to the named address.

Instructions arrive on a valid/ready handshake. Data memory is reached through a synchronous port, where read data returns in the cycle after the request. Each instruction that reads memory therefore takes two cycles, and the unit drops ready for the second of them. The accumulator value and its zero and carry flags are visible on output ports, so an upstream controller or a test harness can observe them.

Top module: `acc_exec_unit`

## Requirements
- R1: LOAD (opcode 3'b000) copies the byte at the addressed location into the accumulator, sets zero when that byte is 0, and leaves carry unchanged.
- R2: ADD (opcode 3'b010) replaces the accumulator with (accumulator + byte) mod 256, sets carry to the carry out of bit 7, and sets zero when the result is 0.
- R3: SUB (opcode 3'b011) replaces the accumulator with (accumulator - byte) mod 256, sets carry to 1 exactly when the byte is greater than the accumulator (borrow), and sets zero when the result is 0.
- R4: MULTIPLY (opcode 3'b100) keeps the low 8 bits of accumulator times byte, sets zero when those bits are 0, and leaves carry unchanged.
- R5: STORE (opcode 3'b001) raises mem_req_o and mem_we_o in its acceptance cycle with mem_wdata_o equal to the accumulator and mem_addr_o equal to the instruction address. It keeps ready high, and it leaves the accumulator and both flags unchanged.
- R6: A memory-reading instruction (LOAD, ADD, SUB, MULTIPLY) raises mem_req_o with mem_we_o low in its acceptance cycle. Ready is low in the following cycle, and the result is visible on acc_o after the clock edge that ends that cycle.
- R7: Opcodes 3'b101 to 3'b111 are accepted in one cycle with no memory request, and they leave the accumulator and both flags unchanged.
- R8: While reset is asserted, acc_o is 0, zero_o is 0, carry_o is 0, instr_ready_o is 1, and there is no memory request.
- R9: The sequence LOAD a, ADD b, MULTIPLY c, STORE d leaves ((a+b)*c) mod 256 in location d.
- R10: mem_req_o is only ever high in a cycle where an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present |
| instr_ready_o | output | 1 | Unit can accept an instruction this cycle |
| instr_op_i | input | 3 | Opcode |
| instr_addr_i | input | 16 | Memory operand address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable, qualifies mem_req_o |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data (accumulator) |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |

## Verification
The bench builds the unit with its default widths: an 8-bit datapath and a 16-bit address. With these widths, an ADD that carries past 255 and a SUB that borrows can both be reached with small operands, as can a product that wraps past 256. Addresses at the top of the 16-bit space, such as 16'hFFFF, are also exercised. Instructions are issued back to back and with idle gaps. These runs show that a STORE directly after a read picks up the freshly written accumulator, and that ready drops only behind reads.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'b000,
    OP_STORE = 3'b001,
    OP_ADD   = 3'b010,
    OP_SUB   = 3'b011,
    OP_MUL   = 3'b100
  } acc_op_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

  function automatic logic op_reads_mem(logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
  import acc_exec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  input  logic [2:0]        instr_op_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  output logic              instr_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              exec_en_o,
  output logic [2:0]        exec_op_o
);

  seq_state_e state_q;
  logic [2:0] op_q;
  logic       accept, rd_go, st_go;

  assign instr_ready_o = (state_q == SEQ_IDLE);
  assign accept        = instr_valid_i && instr_ready_o;
  assign rd_go         = accept && op_reads_mem(instr_op_i);
  assign st_go         = accept && (instr_op_i == OP_STORE);

  assign mem_req_o  = rd_go || st_go;
  assign mem_we_o   = st_go;
  assign mem_addr_o = instr_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      op_q    <= OP_LOAD;
    end else if (rd_go) begin
      state_q <= SEQ_WAIT;
      op_q    <= instr_op_i;
    end else if (state_q == SEQ_WAIT) begin
      state_q <= SEQ_IDLE;
    end
  end

  assign exec_en_o = (state_q == SEQ_WAIT);
  assign exec_op_o = op_q;

  // read data wait lasts exactly one cycle
  p_wait_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_WAIT) |=> (state_q == SEQ_IDLE));

  p_ready_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o && op_reads_mem(instr_op_i)) |=> !instr_ready_o);

  p_undef_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o && (instr_op_i > 3'b100)) |-> !mem_req_o);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              carry_we_o
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sum, dif;
  logic [PROD_W-1:0] prod;

  assign sum  = {1'b0, acc_i} + {1'b0, opnd_i};
  assign dif  = {1'b0, acc_i} - {1'b0, opnd_i};
  assign prod = PROD_W'(acc_i) * PROD_W'(opnd_i);

  always_comb begin
    res_o      = acc_i;
    carry_o    = 1'b0;
    carry_we_o = 1'b0;
    case (op_i)
      OP_LOAD: res_o = opnd_i;
      OP_ADD: begin
        res_o      = sum[DATA_W-1:0];
        carry_o    = sum[DATA_W];
        carry_we_o = 1'b1;
      end
      OP_SUB: begin
        res_o      = dif[DATA_W-1:0];
        carry_o    = dif[DATA_W]; // borrow
        carry_we_o = 1'b1;
      end
      OP_MUL:  res_o = prod[DATA_W-1:0];
      default: res_o = acc_i;
    endcase
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              carry_i,
  input  logic              carry_we_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              carry_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o   <= '0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
    end else if (upd_i) begin
      acc_o  <= res_i;
      zero_o <= (res_i == '0);
      if (carry_we_i) carry_o <= carry_i;
    end
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_valid_i,
  output logic              instr_ready_o,
  input  logic [2:0]        instr_op_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              zero_o,
  output logic              carry_o
);

  logic              exec_en;
  logic [2:0]        exec_op;
  logic [DATA_W-1:0] alu_res;
  logic              alu_carry, alu_carry_we;

  acc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_op_i    (instr_op_i),
    .instr_addr_i  (instr_addr_i),
    .instr_ready_o (instr_ready_o),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .exec_en_o     (exec_en),
    .exec_op_o     (exec_op)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i       (exec_op),
    .acc_i      (acc_o),
    .opnd_i     (mem_rdata_i),
    .res_o      (alu_res),
    .carry_o    (alu_carry),
    .carry_we_o (alu_carry_we)
  );

  acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (exec_en),
    .res_i      (alu_res),
    .carry_i    (alu_carry),
    .carry_we_i (alu_carry_we),
    .acc_o      (acc_o),
    .zero_o     (zero_o),
    .carry_o    (carry_o)
  );

  assign mem_wdata_o = acc_o;

  p_load_copies_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && exec_op == OP_LOAD) |=> (acc_o == $past(mem_rdata_i)));

  p_mul_keeps_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_en && exec_op == OP_MUL) |=> $stable(carry_o));

  p_store_keeps_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_ready_o && instr_op_i == OP_STORE)
      |=> ($stable(acc_o) && $stable(zero_o) && $stable(carry_o)));

  p_req_on_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (instr_valid_i && instr_ready_o));

  p_reset_idle_r8: assert property (@(posedge clk_i)
    !rst_ni |-> (instr_ready_o && acc_o == '0 && !zero_o && !carry_o));

endmodule

// File: tb/tb_acc_exec_unit.sv
`timescale 1ns/1ps
module tb_acc_exec_unit;

  localparam int DW = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid_i;
  logic          instr_ready_o;
  logic [2:0]    instr_op_i;
  logic [AW-1:0] instr_addr_i;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i;
  logic [DW-1:0] acc_o;
  logic          zero_o, carry_o;

  always #2 clk = ~clk;

  acc_exec_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid_i), .instr_ready_o(instr_ready_o),
    .instr_op_i(instr_op_i), .instr_addr_i(instr_addr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .acc_o(acc_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] ram     [logic [15:0]];
  logic [7:0] ref_mem [logic [15:0]];

  function automatic logic [7:0] ram_get(logic [15:0] a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  function automatic logic [7:0] ref_get(logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic string rtag(logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R5";
      3'b010:  return "R2";
      3'b011:  return "R3";
      3'b100:  return "R4";
      default: return "R7";
    endcase
  endfunction

  // memory model: synchronous read, one cycle latency
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) ram[mem_addr_o] = mem_wdata_o;
      else          mem_rdata_i <= ram_get(mem_addr_o);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // reference model state and scoreboard queue {op, acc, zero, carry}
  logic [7:0]  m_acc = 8'h00;
  logic        m_z = 1'b0, m_c = 1'b0;
  logic [12:0] exp_q[$];

  task automatic issue(input logic [2:0] op, input logic [15:0] a, input int gap);
    logic [7:0]  v;
    logic [8:0]  s;
    logic [15:0] p;
    v = ref_get(a);
    case (op)
      3'b000: begin m_acc = v; m_z = (v == 8'h00); end
      3'b001: ref_mem[a] = m_acc;
      3'b010: begin s = {1'b0, m_acc} + {1'b0, v}; m_acc = s[7:0]; m_c = s[8]; m_z = (m_acc == 0); end
      3'b011: begin m_c = (v > m_acc); m_acc = m_acc - v; m_z = (m_acc == 0); end
      3'b100: begin p = 16'(m_acc) * 16'(v); m_acc = p[7:0]; m_z = (m_acc == 0); end
      default: ;
    endcase
    exp_q.push_back({op, m_acc, m_z, m_c});
    if (gap > 0) begin
      repeat (gap) @(posedge clk);
      #1;
    end
    instr_valid_i = 1'b1;
    instr_op_i    = op;
    instr_addr_i  = a;
    forever begin
      @(negedge clk);
      if (instr_ready_o) break;
    end
    @(posedge clk);
    #1 instr_valid_i = 1'b0;
  endtask

  // monitor: pops expectations as results appear
  int         cd = 0;
  bit         rdy_chk = 0;
  logic [7:0] last_acc = 8'h00;
  initial begin
    forever begin
      @(negedge clk);
      if (rdy_chk) begin
        check(instr_ready_o == 1'b0, "R6", "ready low during read wait", instr_ready_o, 0);
        rdy_chk = 0;
      end
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected completion", 0, 1);
          end else begin
            logic [12:0] e;
            e = exp_q.pop_front();
            check(acc_o == e[9:2], rtag(e[12:10]), "acc", acc_o, e[9:2]);
            check(zero_o == e[1], rtag(e[12:10]), "zero", zero_o, e[1]);
            check(carry_o == e[0], rtag(e[12:10]), "carry", carry_o, e[0]);
            last_acc = acc_o;
          end
        end
      end
      if (rst_n && instr_valid_i && instr_ready_o) begin
        case (instr_op_i)
          3'b000, 3'b010, 3'b011, 3'b100: begin
            check(mem_req_o && !mem_we_o && mem_addr_o == instr_addr_i, "R6",
                  "read request", {mem_req_o, mem_we_o}, 2'b10);
            cd = 2;
            rdy_chk = 1;
          end
          3'b001: begin
            check(mem_req_o && mem_we_o && mem_wdata_o == last_acc && mem_addr_o == instr_addr_i,
                  "R5", "store request/data", mem_wdata_o, last_acc);
            cd = 1;
          end
          default: begin
            check(!mem_req_o, "R7", "undefined op memory request", mem_req_o, 0);
            cd = 1;
          end
        endcase
      end else begin
        check(!mem_req_o, "R10", "request without accept", mem_req_o, 0);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    instr_valid_i = 1'b0;
    instr_op_i    = 3'b000;
    instr_addr_i  = '0;
    rst_n         = 1'b0;
    foreach_init();
    repeat (3) @(negedge clk);
    check(acc_o == 0, "R8", "reset acc", acc_o, 0);
    check(!zero_o && !carry_o, "R8", "reset flags", {zero_o, carry_o}, 0);
    check(instr_ready_o && !mem_req_o, "R8", "reset ready/req", {instr_ready_o, mem_req_o}, 2'b10);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R9 sequence: (7+5)*3 into 0x0070
    issue(3'b000, 16'h0010, 0);
    issue(3'b010, 16'h0020, 0);
    issue(3'b100, 16'h0030, 0);
    issue(3'b001, 16'h0070, 0);
    // carry, borrow, wrap, zero cases
    issue(3'b000, 16'hFFFF, 2);
    issue(3'b010, 16'h1234, 0);   // 200+128 carries
    issue(3'b011, 16'h0050, 1);   // borrow
    issue(3'b011, 16'h0060, 0);   // no borrow
    issue(3'b100, 16'h0040, 0);   // product 0, carry held
    issue(3'b000, 16'h0050, 0);
    issue(3'b010, 16'h0060, 0);   // 255+1 -> 0, carry
    issue(3'b100, 16'h1234, 0);
    issue(3'b101, 16'h0010, 0);
    issue(3'b110, 16'h0020, 1);
    issue(3'b111, 16'h0030, 0);
    issue(3'b000, 16'h0030, 0);
    issue(3'b100, 16'h0090, 0);   // 3*100 = 300 wraps to 44
    issue(3'b001, 16'h0080, 0);
    issue(3'b011, 16'h0030, 0);   // 44-3
    issue(3'b000, 16'h0080, 0);   // reload stored value
    issue(3'b000, 16'h0040, 3);   // zero load

    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R6", "all results observed", exp_q.size(), 0);
    check(ram_get(16'h0070) == 8'd36, "R9", "(a+b)*c stored", ram_get(16'h0070), 36);
    check(ram_get(16'h0080) == ref_get(16'h0080), "R5", "stored byte", ram_get(16'h0080),
          ref_get(16'h0080));
    finished = 1;
    summary();
    $finish;
  end

  task automatic foreach_init();
    logic [15:0] al [8] = '{16'h0010, 16'h0020, 16'h0030, 16'hFFFF,
                            16'h1234, 16'h0040, 16'h0050, 16'h0060};
    logic [7:0]  vl [8] = '{8'd7, 8'd5, 8'd3, 8'd200, 8'h80, 8'd0, 8'd255, 8'd1};
    for (int i = 0; i < 8; i++) begin
      ram[al[i]]     = vl[i];
      ref_mem[al[i]] = vl[i];
    end
    ram[16'h0090]     = 8'd100;
    ref_mem[16'h0090] = 8'd100;
  endtask

endmodule